// File: doc/BRIEF.md
# Video Line Packet Scheduler

This block decides, line by line, which packets a serial display link sends in video mode. A small configuration store holds twelve 32-bit schedule words, eight 16-bit length values and a start-of-line delay. Each schedule word describes three packet slots. Each slot has an enable bit, a 6-bit data type and a 3-bit selector that picks one of the eight lengths. The words pair up into six line kinds.

When the display timing logic strobes `line_start` with a line kind, the block latches that kind's two schedule words. It waits the programmed delay and then presents one request for each enabled slot on a valid/ready port, in slot order. Each request carries the data type, the word count and a short/long flag. After the last request is accepted, the block pulses `line_done` for one cycle. In the same cycle, `line_lp` tells the downstream link whether it may fall back to low-power for the rest of the line.

Header ECC, payload checksums, lane striping, PHY signalling and pixel fetch are left to neighbouring blocks. The configuration is expected to stay unchanged while `busy` is high.

Top module: `vid_pkt_sched`

## Requirements
- R1: After synchronous reset, `pkt_valid`, `line_done`, `line_lp` and `busy` are 0, and every configuration register is 0.
- R2: Configuration write map, with a write taking effect when `cfg_we` is 1 at a clock edge. Addresses 0..11 hold the schedule words; line kind k uses address 2k as its low word and 2k+1 as its high word. Addresses 12..15 hold length pairs: address 12+i holds length 2i in bits [15:0] and length 2i+1 in bits [31:16]. Address 16 holds the start-of-line delay in bits [15:0].
- R3: Slot fields in a schedule word: slot 0 uses selector [2:0], type [8:3] and enable [9]. Slot 1 uses [12:10], [18:13] and [19]. Slot 2 uses [22:20], [28:23] and [29].
- R4: A line visits slots 0,1,2 of the low word and then slots 0,1,2 of the high word. A disabled slot costs no cycle: the next enabled slot is presented in the cycle right after the previous handshake.
- R5: A data type whose low nibble is 0x0 to 0x8 is short: `pkt_long`=0 and `pkt_wc`=0, whatever the selector holds. Any other type is long: `pkt_long`=1 and `pkt_wc` equals the selected length.
- R6: A request advances only on a cycle where `pkt_valid` and `pkt_ready` are both 1. While ready is low, valid and all payload fields hold.
- R7: `line_done` is high for exactly one cycle, the cycle after the last handshake of the line. `line_lp` is 1 in that cycle exactly when bit 30 of either of the line's two words is set, and is 0 at all other times.
- R8: With delay D, the first `pkt_valid` (or `line_done` for an empty line) appears in the (D+1)-th cycle after the clock edge that accepts `line_start`.
- R9: `line_start` is accepted only while `busy` is 0, and the kind is latched at that edge. A strobe while busy is ignored and queues nothing.
- R10: A line with no enabled slot presents no request and gives only `line_done`. Line kinds 6 and 7 behave as empty lines with `line_lp`=0.
- R11: `busy` is 1 from the accepting edge through the `line_done` cycle, and `pkt_valid` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| line_start | input | 1 | Start-of-line strobe |
| line_kind | input | 3 | Line kind for the line being started |
| pkt_valid | output | 1 | Packet request valid |
| pkt_ready | input | 1 | Downstream accepts the request |
| pkt_dtype | output | 6 | Packet data type |
| pkt_wc | output | 16 | Word count (0 for short packets) |
| pkt_long | output | 1 | 1 for a long packet |
| line_done | output | 1 | One-cycle end-of-line pulse |
| line_lp | output | 1 | Low-power permission, valid with line_done |
| busy | output | 1 | A line is in progress |

## Verification
The bench programs a non-burst schedule with sync-end packets and walks every line kind against a table of expected packets. Dropping the length-pair half selection, or swapping low and high words, would show up as wrong word counts or a wrong packet order. Directed cases aim at slots that are disabled between enabled ones: a design that spends a cycle per slot would present the second packet late. Other cases cover a selector set on a short packet (a leaky design would show a nonzero count), an empty line, out-of-range kinds, and a low-power flag placed only in the high word. Further cases stall ready, which a design must absorb without changing the payload, and send a second strobe mid-line, which a careless design would queue or use to swap the line kind. The start-of-line delay is measured in cycles, so an off-by-one in the countdown cannot hide.

// File: rtl/vps_pkg.sv
package vps_pkg;

    localparam int WORD_W     = 32;
    localparam int DT_W       = 6;
    localparam int SEL_W      = 3;
    localparam int LEN_W      = 16;
    localparam int SLOT_W     = 1 + DT_W + SEL_W;
    localparam int SLOTS_PW   = 3;
    localparam int LP_BIT     = 30;
    localparam int LINE_KINDS = 6;
    localparam int NUM_WORDS  = 2 * LINE_KINDS;
    localparam int NUM_LENS   = 1 << SEL_W;
    localparam int LEN_REGS   = NUM_LENS / 2;
    localparam int LINE_SLOTS = 2 * SLOTS_PW;
    localparam int ADDR_LEN0  = NUM_WORDS;
    localparam int ADDR_SOL   = ADDR_LEN0 + LEN_REGS;
    localparam int ADDR_W     = $clog2(ADDR_SOL + 1);
    localparam int KIND_W     = $clog2(LINE_KINDS + 2);

    typedef struct packed {
        logic             en;
        logic [DT_W-1:0]  dt;
        logic [SEL_W-1:0] sel;
    } slot_t;

    typedef struct packed {
        logic [DT_W-1:0]  dt;
        logic [LEN_W-1:0] wc;
        logic             lng;
    } pkt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    function automatic logic dt_is_long(input logic [DT_W-1:0] dt);
        return dt[3:0] >= 4'h9;
    endfunction

    function automatic slot_t slot_field(input logic [1:0][WORD_W-1:0] w,
                                        input int idx);
        return slot_t'(w[idx / SLOTS_PW][(idx % SLOTS_PW) * SLOT_W +: SLOT_W]);
    endfunction

endpackage

// File: rtl/vps_cfg_regs.sv
module vps_cfg_regs
    import vps_pkg::*;
#(
    parameter int NWORDS = NUM_WORDS,
    parameter int NLREGS = LEN_REGS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NWORDS-1:0][WORD_W-1:0] seq_words,
    output logic [2*NLREGS-1:0][LEN_W-1:0] lens,
    output logic [LEN_W-1:0]              sol_delay
);
    localparam int LBASE = NWORDS;
    localparam int SADDR = NWORDS + NLREGS;

    for (genvar g = 0; g < NWORDS; g++) begin : g_seq
        always_ff @(posedge clk) begin
            if (rst)
                seq_words[g] <= '0;
            else if (we && addr == ADDR_W'(g))
                seq_words[g] <= wdata;
        end
    end

    for (genvar g = 0; g < NLREGS; g++) begin : g_len
        always_ff @(posedge clk) begin
            if (rst) begin
                lens[2*g]   <= '0;
                lens[2*g+1] <= '0;
            end else if (we && addr == ADDR_W'(LBASE + g)) begin
                lens[2*g]   <= wdata[LEN_W-1:0];
                lens[2*g+1] <= wdata[2*LEN_W-1:LEN_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sol_delay <= '0;
        else if (we && addr == ADDR_W'(SADDR))
            sol_delay <= wdata[LEN_W-1:0];
    end

endmodule

// File: rtl/vps_slot_pick.sv
module vps_slot_pick
    import vps_pkg::*;
#(
    parameter int NSLOTS = LINE_SLOTS,
    parameter int NL     = NUM_LENS
) (
    input  logic [1:0][WORD_W-1:0]   line_words,
    input  logic [NSLOTS-1:0]        pend,
    input  logic [NL-1:0][LEN_W-1:0] lens,
    output logic [NSLOTS-1:0]        pick_oh,
    output pkt_t                     pkt
);
    slot_t slots [NSLOTS];

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        assign slots[g] = slot_field(line_words, g);
    end

    assign pick_oh = pend & (~pend + NSLOTS'(1));

    logic [DT_W-1:0]  dt_m;
    logic [SEL_W-1:0] sel_m;
    logic             lng;

    always_comb begin
        dt_m  = '0;
        sel_m = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (pick_oh[i]) begin
                dt_m  = dt_m  | slots[i].dt;
                sel_m = sel_m | slots[i].sel;
            end
        end
        lng     = dt_is_long(dt_m);
        pkt.dt  = dt_m;
        pkt.lng = lng;
        pkt.wc  = lng ? lens[sel_m] : '0;
    end

endmodule

// File: rtl/vps_line_fsm.sv
module vps_line_fsm
    import vps_pkg::*;
#(
    parameter int NWORDS = NUM_WORDS,
    parameter int KINDS  = LINE_KINDS,
    parameter int NSLOTS = LINE_SLOTS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_start,
    input  logic [KIND_W-1:0]             line_kind,
    input  logic [NWORDS-1:0][WORD_W-1:0] seq_words,
    input  logic [LEN_W-1:0]              sol_delay,
    input  logic                          hs,
    input  logic [NSLOTS-1:0]             pick_oh,
    output logic [1:0][WORD_W-1:0]        line_words,
    output logic [NSLOTS-1:0]             pend,
    output logic                          pkt_valid,
    output logic                          line_done,
    output logic                          line_lp,
    output logic                          busy
);
    seq_state_t            st;
    logic [LEN_W-1:0]      cnt;
    logic [KIND_W-1:0]     kind_q;
    logic                  lp_q;
    logic [1:0][WORD_W-1:0] new_words;
    logic [NSLOTS-1:0]     new_mask;

    always_comb begin
        new_words = '0;
        if (int'(line_kind) < KINDS) begin
            new_words[0] = seq_words[2 * int'(line_kind)];
            new_words[1] = seq_words[2 * int'(line_kind) + 1];
        end
    end

    for (genvar g = 0; g < NSLOTS; g++) begin : g_mask
        slot_t s;
        assign s           = slot_field(new_words, g);
        assign new_mask[g] = s.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            kind_q     <= '0;
            lp_q       <= 1'b0;
            line_words <= '0;
            pend       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (line_start) begin
                        kind_q     <= line_kind;
                        line_words <= new_words;
                        pend       <= new_mask;
                        lp_q       <= new_words[0][LP_BIT] | new_words[1][LP_BIT];
                        cnt        <= sol_delay;
                        st         <= (sol_delay == '0) ? ST_RUN : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    cnt <= cnt - LEN_W'(1);
                    if (cnt == LEN_W'(1))
                        st <= ST_RUN;
                end
                ST_RUN: begin
                    if (pend == '0)
                        st <= ST_IDLE;
                    else if (hs)
                        pend <= pend & ~pick_oh;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign pkt_valid = (st == ST_RUN) && (pend != '0);
    assign line_done = (st == ST_RUN) && (pend == '0);
    assign line_lp   = line_done && lp_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done); // R7
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && hs) |=> ($countones(pend) + 1 == $countones($past(pend)))); // R4
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(kind_q)); // R9

endmodule

// File: rtl/vid_pkt_sched.sv
module vid_pkt_sched
    import vps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic                line_start,
    input  logic [KIND_W-1:0]   line_kind,
    output logic                pkt_valid,
    input  logic                pkt_ready,
    output logic [DT_W-1:0]     pkt_dtype,
    output logic [LEN_W-1:0]    pkt_wc,
    output logic                pkt_long,
    output logic                line_done,
    output logic                line_lp,
    output logic                busy
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] seq_words;
    logic [NUM_LENS-1:0][LEN_W-1:0]   lens;
    logic [LEN_W-1:0]                 sol_delay;
    logic [1:0][WORD_W-1:0]           line_words;
    logic [LINE_SLOTS-1:0]            pend;
    logic [LINE_SLOTS-1:0]            pick_oh;
    pkt_t                             pkt;
    logic                             hs;

    vps_cfg_regs #(.NWORDS(NUM_WORDS), .NLREGS(LEN_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .seq_words (seq_words),
        .lens      (lens),
        .sol_delay (sol_delay)
    );

    vps_line_fsm #(.NWORDS(NUM_WORDS), .KINDS(LINE_KINDS), .NSLOTS(LINE_SLOTS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .line_kind  (line_kind),
        .seq_words  (seq_words),
        .sol_delay  (sol_delay),
        .hs         (hs),
        .pick_oh    (pick_oh),
        .line_words (line_words),
        .pend       (pend),
        .pkt_valid  (pkt_valid),
        .line_done  (line_done),
        .line_lp    (line_lp),
        .busy       (busy)
    );

    vps_slot_pick #(.NSLOTS(LINE_SLOTS), .NL(NUM_LENS)) u_pick (
        .line_words (line_words),
        .pend       (pend),
        .lens       (lens),
        .pick_oh    (pick_oh),
        .pkt        (pkt)
    );

    assign hs        = pkt_valid && pkt_ready;
    assign pkt_dtype = pkt.dt;
    assign pkt_wc    = pkt.wc;
    assign pkt_long  = pkt.lng;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_dtype)
                                       && $stable(pkt_wc) && $stable(pkt_long))); // R6
    AST_SHORT_NO_WC: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_long) |-> (pkt_wc == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pkt_valid); // R11

endmodule

// File: tb/vid_pkt_sched_bench.sv
module vid_pkt_sched_bench;
    import vps_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [WORD_W-1:0] cfg_wdata = '0;
    logic line_start = 1'b0;
    logic [KIND_W-1:0] line_kind = '0;
    logic pkt_ready = 1'b1;
    logic pkt_valid, pkt_long, line_done, line_lp, busy;
    logic [DT_W-1:0] pkt_dtype;
    logic [LEN_W-1:0] pkt_wc;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vid_pkt_sched u_vid_pkt_sched (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .line_start(line_start), .line_kind(line_kind), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_dtype(pkt_dtype), .pkt_wc(pkt_wc), .pkt_long(pkt_long),
        .line_done(line_done), .line_lp(line_lp), .busy(busy)
    );

    localparam logic [15:0] L0 = 16'd7,   L1 = 16'd100, L2 = 16'd200, L3 = 16'd5760;
    localparam logic [15:0] L4 = 16'd300, L5 = 16'd42,  L6 = 16'd8,   L7 = 16'd9;

    function automatic logic [9:0] sl(input logic en, input logic [5:0] dt, input logic [2:0] sel);
        return {en, dt, sel};
    endfunction

    function automatic logic [31:0] wd(input logic lp, input logic [9:0] s2,
                                       input logic [9:0] s1, input logic [9:0] s0);
        return {1'b0, lp, s2, s1, s0};
    endfunction

    // kind, dtype, wc, long, last-of-line, lp
    typedef struct packed {
        logic [2:0]  kind;
        logic [5:0]  dt;
        logic [15:0] wc;
        logic        lng;
        logic        last;
        logic        lp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 6'h01, 16'd0, 1'b0, 1'b0, 1'b1},
        '{3'd0, 6'h19, L1,    1'b1, 1'b0, 1'b1},
        '{3'd0, 6'h31, 16'd0, 1'b0, 1'b1, 1'b1},
        '{3'd1, 6'h11, 16'd0, 1'b0, 1'b0, 1'b1},
        '{3'd1, 6'h19, L1,    1'b1, 1'b0, 1'b1},
        '{3'd1, 6'h31, 16'd0, 1'b0, 1'b1, 1'b1},
        '{3'd2, 6'h21, 16'd0, 1'b0, 1'b0, 1'b1},
        '{3'd2, 6'h19, L1,    1'b1, 1'b0, 1'b1},
        '{3'd2, 6'h31, 16'd0, 1'b0, 1'b1, 1'b1},
        '{3'd3, 6'h21, 16'd0, 1'b0, 1'b0, 1'b0},
        '{3'd3, 6'h19, L1,    1'b1, 1'b0, 1'b0},
        '{3'd3, 6'h31, 16'd0, 1'b0, 1'b0, 1'b0},
        '{3'd3, 6'h19, L2,    1'b1, 1'b0, 1'b0},
        '{3'd3, 6'h3E, L3,    1'b1, 1'b0, 1'b0},
        '{3'd3, 6'h19, L4,    1'b1, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // ends at the first negedge after the accepting edge
    task automatic start_line(input int kind);
        @(negedge clk);
        line_start = 1'b1; line_kind = KIND_W'(kind);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic take_pkt(input string req, input logic [5:0] dt,
                            input logic [15:0] wc, input logic lng);
        int n = 0;
        while (!pkt_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(pkt_valid == 1'b1, req, "valid", pkt_valid, 1);
        check(pkt_dtype == dt, req, "dtype", pkt_dtype, dt);
        check(pkt_wc == wc, req, "word count", pkt_wc, wc);
        check(pkt_long == lng, req, "long flag", pkt_long, lng);
        @(negedge clk);
    endtask

    task automatic expect_done(input string req, input logic lp);
        check(line_done == 1'b1, req, "line_done", line_done, 1);
        check(line_lp == lp, req, "line_lp", line_lp, lp);
        @(negedge clk);
        check(line_done == 1'b0, "R7", "line_done width", line_done, 0);
        check(busy == 1'b0, "R11", "busy after done", busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(pkt_valid == 0, "R1", "pkt_valid", pkt_valid, 0);
        check(line_done == 0, "R1", "line_done", line_done, 0);
        check(line_lp == 0, "R1", "line_lp", line_lp, 0);
        check(busy == 0, "R1", "busy", busy, 0);
        // R1: a line on reset-valued config is empty
        start_line(3);
        expect_done("R1", 1'b0);

        // R2 R3: program the schedule
        wr(0,  wd(1, sl(1, 6'h31, 0), sl(1, 6'h19, 1), sl(1, 6'h01, 0)));
        wr(2,  wd(1, sl(1, 6'h31, 0), sl(1, 6'h19, 1), sl(1, 6'h11, 0)));
        wr(4,  wd(1, sl(1, 6'h31, 0), sl(1, 6'h19, 1), sl(1, 6'h21, 0)));
        wr(6,  wd(0, sl(1, 6'h31, 0), sl(1, 6'h19, 1), sl(1, 6'h21, 0)));
        wr(7,  wd(0, sl(1, 6'h19, 4), sl(1, 6'h3E, 3), sl(1, 6'h19, 2)));
        wr(8,  wd(0, sl(1, 6'h29, 5), sl(0, 6'h3E, 3), sl(0, 6'h19, 2)));
        wr(9,  wd(1, sl(0, 6'h19, 1), sl(0, 6'h19, 1), sl(1, 6'h05, 6)));
        wr(12, {L1, L0});
        wr(13, {L3, L2});
        wr(14, {L5, L4});
        wr(15, {L7, L6});

        // Table walk: R2 R3 R4 R5 R7
        pkt_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (i == 0 || VECS[i-1].last)
                start_line(int'(VECS[i].kind));
            take_pkt("R4", VECS[i].dt, VECS[i].wc, VECS[i].lng);
            if (VECS[i].last)
                expect_done("R7", VECS[i].lp);
        end

        // R4 R5: disabled slots skipped back to back, selector ignored on short type, lp from high word
        start_line(4);
        check(pkt_valid == 1 && pkt_dtype == 6'h29, "R4", "first of sparse line", pkt_dtype, 6'h29);
        check(pkt_wc == L5, "R5", "long wc sel 5", pkt_wc, L5);
        @(negedge clk);
        check(pkt_valid == 1 && pkt_dtype == 6'h05, "R4", "no gap cycle", pkt_dtype, 6'h05);
        check(pkt_wc == 0 && pkt_long == 0, "R5", "short ignores selector", pkt_wc, 0);
        @(negedge clk);
        expect_done("R7", 1'b1);

        // R10: empty kind and out-of-range kind
        start_line(5);
        check(pkt_valid == 0, "R10", "no request on empty line", pkt_valid, 0);
        expect_done("R10", 1'b0);
        start_line(6);
        check(pkt_valid == 0, "R10", "no request on kind 6", pkt_valid, 0);
        expect_done("R10", 1'b0);

        // R8: start-of-line delay
        wr(16, 32'd3);
        start_line(2);
        begin
            int k = 1;
            while (!pkt_valid && k < 40) begin
                check(busy == 1, "R11", "busy during delay", busy, 1);
                @(negedge clk);
                k++;
            end
            check(k == 4, "R8", "cycles to first request", k, 4);
        end
        take_pkt("R8", 6'h21, 16'd0, 1'b0);
        take_pkt("R8", 6'h19, L1, 1'b1);
        take_pkt("R8", 6'h31, 16'd0, 1'b0);
        expect_done("R8", 1'b1);
        wr(16, 32'd0);

        // R6: stall holds payload
        pkt_ready = 1'b0;
        start_line(3);
        for (int j = 0; j < 3; j++) begin
            check(pkt_valid == 1 && pkt_dtype == 6'h21, "R6", "held under stall", pkt_dtype, 6'h21);
            @(negedge clk);
        end
        // R9: second strobe while busy is ignored
        start_line(0);
        check(pkt_dtype == 6'h21, "R9", "kind kept after busy strobe", pkt_dtype, 6'h21);
        pkt_ready = 1'b1;
        for (int i = 9; i < NV; i++)
            take_pkt("R9", VECS[i].dt, VECS[i].wc, VECS[i].lng);
        expect_done("R9", 1'b0);
        check(pkt_valid == 0, "R9", "ignored strobe not queued", pkt_valid, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule